// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block keeps one segment register for each of up to five flash chip selects. Each register cuts one slice out of a shared flash address window, measured in 8 MB units. The block checks every register write against the hardware rules: bounds that are fixed by hardware are put back, and windows that lie outside the overall window are dropped. It raises flags for segments that are misaligned or that overlap another chip select.

It has two lookups, and both are combinational from the stored registers. A bus address is decoded to a one-hot chip-select hit and an offset within that device. A separate access port takes a chip select and a device offset, and folds the offset back into that segment's size.

Top module: `seg_window_decoder`

## Requirements
- R1: A segment register stores its end in data bits [31:24] and its start in bits [23:16], both as address bits [30:23] (8 MB units); bits [15:0] are discarded. After reset, chip select 0 spans 64 MB from the window base (unit 0x40), and each further chip select follows with a 32 MB slice (0x48-0x4C, 0x4C-0x50, 0x50-0x54, 0x54-0x58).
- R2: A bus address with bit 31 clear and bits [30:23] in [start, end) of a segment hits that chip select, and `bus_offset` equals the bus address minus start·8 MB. With no hit, `cs_hit` and `bus_offset` are zero.
- R3: When segments overlap, only the lowest-numbered matching chip select is set in `cs_hit`.
- R4: Every stored write to chip select 0 has its start forced to the window base.
- R5: With LOCK_LAST_END set (the default), every stored write to the last chip select has its end forced to its reset end (0x58).
- R6: A write whose corrected end is at or below the base unit (0x40), or whose start is above base plus window size (0x60), leaves the register unchanged and clears both flags.
- R7: A write whose 32-bit data equals the current register image ({end, start, 16'h0}) is ignored and leaves both flags unchanged. Writes to a chip select number of NUM_CS or more are ignored.
- R8: After an accepted write, `align_err` is 1 when the size (end − start, 0 if end ≤ start) is nonzero and start is not a multiple of it; otherwise 0. The write is stored in either case.
- R9: After an accepted write, `overlap_err` is 1 when the new range overlaps the range of any other chip select (new start < other end and new end > other start); otherwise 0. The write is stored in either case.
- R10: For the access port, with size S units for `acc_cs`, `dev_offset` = ((`acc_off`[31:23] mod S) << 23) | `acc_off`[22:0], and `wrap_err` = (`acc_off`[31:23] ≥ S). When S is 0 or `acc_cs` ≥ NUM_CS, `dev_offset` is 0 and `wrap_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_cs | input | CSW | Chip select whose register is written |
| wr_data | input | 32 | Write data: end [31:24], start [23:16] |
| bus_addr | input | 32 | Bus address to decode |
| acc_cs | input | CSW | Chip select for offset folding |
| acc_off | input | 32 | Device offset to fold |
| cs_hit | output | NUM_CS | One-hot chip-select hit for bus_addr |
| bus_offset | output | 32 | Offset of bus_addr inside the hit segment |
| dev_offset | output | 32 | acc_off folded into the segment size |
| wrap_err | output | 1 | acc_off was at or beyond the segment size |
| align_err | output | 1 | Last accepted segment start is misaligned |
| overlap_err | output | 1 | Last accepted segment overlaps another |

## Verification
The decode is first exercised on the reset map, at the first and last byte of each slice, just below the base, and with address bit 31 set. This separates off-by-one errors at start and at end. Targeted writes then try to move the fixed start of chip select 0 and the fixed end of the last chip select, place windows below and above the overall range, repeat an identical value, and build a misaligned segment, an overlapping segment and a zero-size segment. These show whether a write was corrected, dropped, ignored or stored with a flag. The access port is driven with offsets inside the segment, at exactly one size, several sizes beyond, and against a zero-size segment, so that folding can be told apart from clamping. A long pseudo-random phase of mixed writes and probes is compared against the behavioural model on every clock.

// File: rtl/seg_window_decoder.sv
module seg_window_decoder #(
  parameter int NUM_CS        = 5,
  parameter int WIN_BASE_U    = 64,
  parameter int WIN_SIZE_U    = 32,
  parameter int FIRST_U       = 8,
  parameter int SLICE_U       = 4,
  parameter bit LOCK_LAST_END = 1'b1,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSW-1:0]    wr_cs,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       bus_addr,
  input  logic [CSW-1:0]    acc_cs,
  input  logic [31:0]       acc_off,
  output logic [NUM_CS-1:0] cs_hit,
  output logic [31:0]       bus_offset,
  output logic [31:0]       dev_offset,
  output logic              wrap_err,
  output logic              align_err,
  output logic              overlap_err
);

  localparam logic [7:0] BASE8 = 8'(WIN_BASE_U);

  function automatic logic [7:0] dflt_start(int i);
    return 8'((i == 0) ? WIN_BASE_U : WIN_BASE_U + FIRST_U + (i - 1) * SLICE_U);
  endfunction

  function automatic logic [7:0] dflt_end(int i);
    return 8'(int'(dflt_start(i)) + ((i == 0) ? FIRST_U : SLICE_U));
  endfunction

  logic [7:0] st [NUM_CS];
  logic [7:0] en [NUM_CS];

  // write validation
  logic           wr_ok, changed, in_range, n_mis, n_ovl;
  logic [CSW-1:0] w_idx;
  logic [7:0]     n_st, n_en, n_size;

  assign wr_ok   = int'(wr_cs) < NUM_CS;
  assign w_idx   = wr_ok ? wr_cs : '0;
  assign changed = wr_data != {en[w_idx], st[w_idx], 16'h0000};

  always_comb begin
    n_st = wr_data[23:16];
    n_en = wr_data[31:24];
    if (wr_cs == '0) n_st = BASE8;
    if (LOCK_LAST_END && wr_cs == CSW'(NUM_CS - 1)) n_en = dflt_end(NUM_CS - 1);
  end

  assign in_range = !(int'(n_en) <= WIN_BASE_U || int'(n_st) > WIN_BASE_U + WIN_SIZE_U);
  assign n_size   = (n_en > n_st) ? n_en - n_st : 8'd0;
  assign n_mis    = (n_size != 8'd0) && ((n_st % n_size) != 8'd0);

  always_comb begin
    n_ovl = 1'b0;
    for (int j = 0; j < NUM_CS; j++)
      if (CSW'(j) != wr_cs && n_st < en[j] && n_en > st[j]) n_ovl = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        st[i] <= dflt_start(i);
        en[i] <= dflt_end(i);
      end
      align_err   <= 1'b0;
      overlap_err <= 1'b0;
    end else if (wr_en && wr_ok && changed) begin
      align_err   <= in_range && n_mis;
      overlap_err <= in_range && n_ovl;
      if (in_range) begin
        st[w_idx] <= n_st;
        en[w_idx] <= n_en;
      end
    end
  end

  // bus address decode, lowest chip select wins
  logic       found;
  logic [7:0] b_u;
  assign b_u = bus_addr[30:23];

  always_comb begin
    cs_hit     = '0;
    bus_offset = '0;
    found      = 1'b0;
    for (int i = 0; i < NUM_CS; i++)
      if (!found && !bus_addr[31] && b_u >= st[i] && b_u < en[i]) begin
        found      = 1'b1;
        cs_hit[i]  = 1'b1;
        bus_offset = bus_addr - {1'b0, st[i], 23'd0};
      end
  end

  // device offset folding
  logic [CSW-1:0] a_idx;
  logic [7:0]     a_size;
  logic [8:0]     off_u;
  assign a_idx  = (int'(acc_cs) < NUM_CS) ? acc_cs : '0;
  assign a_size = (int'(acc_cs) < NUM_CS && en[a_idx] > st[a_idx]) ? en[a_idx] - st[a_idx] : 8'd0;
  assign off_u  = acc_off[31:23];

  always_comb begin
    if (a_size == 8'd0) begin
      dev_offset = '0;
      wrap_err   = 1'b1;
    end else begin
      dev_offset = {off_u % {1'b0, a_size}, acc_off[22:0]};
      wrap_err   = off_u >= {1'b0, a_size};
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_hit)); // R3
  AST_CS0_BASE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_cs == '0) |=> st[0] == BASE8); // R4
  AST_LAST_END_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (LOCK_LAST_END && wr_en && wr_cs == CSW'(NUM_CS - 1)) |=> en[NUM_CS-1] == dflt_end(NUM_CS - 1)); // R5
  AST_SAME_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data == {en[w_idx], st[w_idx], 16'h0000}) |=> ($stable(align_err) && $stable(overlap_err))); // R7
  AST_NO_WRAP_PASS: assert property (@(posedge clk) disable iff (!rst_n) !wrap_err |-> dev_offset == acc_off); // R10
  AST_HIT_OFFSET_SMALL: assert property (@(posedge clk) disable iff (!rst_n) (cs_hit != '0) |-> bus_offset < 32'h8000_0000); // R2

endmodule

// File: tb/test_seg_window_decoder.sv
module test_seg_window_decoder;
  localparam int N = 5;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_cs = 0, acc_cs = 0;
  logic [31:0] wr_data = 0, bus_addr = 0, acc_off = 0;
  logic [N-1:0] cs_hit;
  logic [31:0] bus_offset, dev_offset;
  logic wrap_err, align_err, overlap_err;

  seg_window_decoder i_seg_window_decoder (.*);

  always #10 clk = ~clk;

  int ms[N], me[N];
  bit mal, mov;
  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic model_reset();
    ms[0] = 64; me[0] = 72;
    for (int i = 1; i < N; i++) begin ms[i] = 72 + (i-1)*4; me[i] = ms[i] + 4; end
    mal = 0; mov = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else if (wr_en && wr_cs < N) begin
      int s, e, sz, c;
      bit ov;
      s = wr_data[23:16]; e = wr_data[31:24]; c = wr_cs;
      if (c == 0) s = 64;
      if (c == N-1) e = 88;
      if (wr_data != {me[c][7:0], ms[c][7:0], 16'h0}) begin
        if (e <= 64 || s > 96) begin mal = 0; mov = 0; end
        else begin
          sz = (e > s) ? e - s : 0;
          ov = 0;
          for (int j = 0; j < N; j++) if (j != c && s < me[j] && e > ms[j]) ov = 1;
          mal = (sz != 0) && (s % sz != 0);
          mov = ov;
          ms[c] = s; me[c] = e;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [N-1:0] eh; logic [31:0] eb, ed; bit ew;
    int u, sz, ou;
    eh = 0; eb = 0;
    u = bus_addr[30:23];
    for (int i = 0; i < N; i++)
      if (eh == 0 && !bus_addr[31] && u >= ms[i] && u < me[i]) begin
        eh[i] = 1; eb = bus_addr - (32'(ms[i]) << 23);
      end
    if (acc_cs >= N || me[acc_cs] <= ms[acc_cs]) begin ed = 0; ew = 1; end
    else begin
      sz = me[acc_cs] - ms[acc_cs]; ou = acc_off[31:23];
      ew = ou >= sz;
      ed = (32'(ou % sz) << 23) | (acc_off & 32'h007F_FFFF);
    end
    tests++;
    if (cs_hit !== eh || bus_offset !== eb) begin
      fails++;
      $display("FAIL %s decode addr=%h: hit=%b off=%h expected hit=%b off=%h", cur_req, bus_addr, cs_hit, bus_offset, eh, eb);
    end
    tests++;
    if (dev_offset !== ed || wrap_err !== ew) begin
      fails++;
      $display("FAIL %s fold cs=%0d off=%h: %h/%b expected %h/%b", cur_req, acc_cs, acc_off, dev_offset, wrap_err, ed, ew);
    end
    tests++;
    if (align_err !== mal || overlap_err !== mov) begin
      fails++;
      $display("FAIL %s flags: align=%b ovl=%b expected %b/%b", cur_req, align_err, overlap_err, mal, mov);
    end
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic wr(input int cs, input logic [31:0] d);
    wr_en = 1; wr_cs = 3'(cs); wr_data = d; step(); wr_en = 0;
  endtask
  task automatic probe(input logic [31:0] a, input int c, input logic [31:0] o);
    bus_addr = a; acc_cs = 3'(c); acc_off = o; step();
  endtask
  task automatic sweep();
    for (int k = 60; k < 100; k++) probe({1'b0, 8'(k), 23'h0}, k % N, 32'(k) << 22);
    for (int k = 60; k < 100; k++) probe({1'b0, 8'(k), 23'h7FFFFF}, k % N, 32'h0);
  endtask

  initial begin
    int lcg;
    repeat (3) step();
    rst_n = 1; step();
    cur_req = "R1";
    probe(32'h2000_0000, 0, 0); probe(32'h23FF_FFFF, 1, 0);
    probe(32'h2400_0000, 2, 0); probe(32'h2BFF_FFFF, 4, 0);
    probe(32'h2C00_0000, 3, 0); probe(32'h1FFF_FFFF, 0, 0);
    probe(32'hA000_0000, 0, 0);
    cur_req = "R2"; sweep();
    cur_req = "R4"; wr(0, 32'h5010_0000); sweep();
    cur_req = "R3"; probe(32'h2400_0000, 0, 0); probe(32'h2600_0004, 0, 0);
    cur_req = "R5"; wr(4, 32'h7056_0000); sweep();
    cur_req = "R6"; wr(2, 32'h4030_0000); sweep(); wr(3, 32'h7061_0000); sweep();
    cur_req = "R8"; wr(3, 32'h5552_0000); sweep();
    cur_req = "R7"; wr(3, 32'h5552_0000); sweep(); wr(7, 32'h6050_0000); sweep();
    wr(3, 32'h5552_0001); sweep();
    cur_req = "R9"; wr(1, 32'h605C_0000); sweep(); wr(2, 32'h605E_0000); sweep();
    cur_req = "R10";
    probe(0, 1, 32'h0100_0000); probe(0, 1, 32'h0200_0000);
    probe(0, 1, 32'h0500_0010); probe(0, 7, 32'h0000_1234);
    wr(2, 32'h5E5E_0000); probe(0, 2, 32'h0000_0040); probe(0, 0, 32'hFFFF_FFFF);
    cur_req = "R2";
    lcg = 12345;
    for (int n = 0; n < 3000; n++) begin
      lcg = lcg * 1103515245 + 12345;
      if (lcg[20:18] == 0)
        wr(int'(lcg[10:8]) % 6, {8'(56 + lcg[27:23] + lcg[29:28]), 8'(56 + lcg[16:12]), 16'(lcg[3:0] == 0 ? lcg[31:16] : 0)});
      else
        probe({lcg[31] & lcg[1], 8'(56 + lcg[29:25]), lcg[22:0]}, int'(lcg[14:12]), {lcg[30:24], lcg[24:0]});
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule